// File: doc/BRIEF.md
# Local Vector Timer

This block is a per-core countdown timer that turns its expiry into an interrupt request. Software writes two registers through a single write port. The first is a 32-bit control word. It sets the request vector, the delivery mode and the trigger mode. It also holds a mask flag and a flag that selects periodic or one-shot operation. The second is an initial count, and writing it loads the counter and starts it. The counter steps down by one in every cycle in which the timer clock enable is high. The current value is always visible on a read-back port, and the stored control word is visible on a second read-back port.

When the count steps from one to zero, the block decides two things from the control word as it stands at that moment. It decides whether to raise a request, and whether to reload from the initial count or to stop. The request leaves as a one-cycle strobe that carries the vector, the delivery mode and the trigger-mode level. The strobe is a plain control pulse with no ready input and therefore no back-pressure. The receiving logic must capture it in the cycle it is high. A later expiry never waits for an earlier request to be taken.

Top module: `lvt_timer`

## Requirements
- R1: After reset, the current count reads 0, the stored control word reads 0x0001_0000 (only mask bit 16 set) and the strobe is low. A count started before any control-word write therefore expires without a request and stops.
- R2: While the count is non-zero, it drops by exactly one in each cycle with `tick_en` high. It holds its value in cycles with `tick_en` low. `cur_count` shows the value after each clock edge.
- R3: When a `tick_en` cycle takes the count from 1 to 0 and mask bit 16 is clear, `irq_valid` is high for exactly the following cycle. In that cycle `irq_vector` = control bits 7:0, `irq_mode` = bits 10:8 and `irq_level` = bit 15.
- R4: When mask bit 16 is set at expiry, no strobe is issued.
- R5: When periodic bit 17 is set at expiry, the count reloads from the initial count and keeps running. This holds whether or not the request was masked. An initial count of 1 then expires on every tick.
- R6: When periodic bit 17 is clear at expiry, the count stays at 0 and later ticks issue no request.
- R7: A write with `wr_sel`=1 loads `wr_data` into both the initial count and the current count, shown on the next cycle. This holds even when the value equals the stored one, and a write in the same cycle as a tick takes priority over that tick.
- R8: A written initial count of 0 leaves the timer stopped: the count stays 0 and ticks issue no request.
- R9: A write with `wr_sel`=0 replaces the whole control word, read back on `ctrl_word`, and leaves the running count untouched. Bits 12, 13 and 14 are stored but have no effect on timing or requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer clock enable; one decrement per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 initial count |
| wr_data | input | 32 | Write data |
| cur_count | output | CNT_W (32) | Current count read-back |
| ctrl_word | output | 32 | Stored control word read-back |
| irq_valid | output | 1 | One-cycle interrupt request strobe |
| irq_vector | output | 8 | Request vector |
| irq_mode | output | 3 | Request delivery mode |
| irq_level | output | 1 | Request trigger-mode bit |

## Verification
The counter is driven with bursts of ticks separated by idle gaps. These show whether the count steps only on enabled cycles and whether a strobe lands exactly one cycle after the 1-to-0 step. Runs under one-shot, periodic, masked-periodic and periodic-with-count-one settings separate the stop behaviour from the reload behaviour. They also show that the reload still happens when no request is raised, and they cover back-to-back strobes. Rewrites with an equal value, a write coinciding with a tick, a zero count and a control-word change in mid-count show whether the restart takes priority over the tick, and whether request fields are taken at expiry rather than at start.

// File: rtl/lvt_timer_pkg.sv
package lvt_timer_pkg;
  localparam int CW_W      = 32;
  localparam int VEC_W     = 8;
  localparam int MODE_W    = 3;
  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int PER_BIT   = 17;
  localparam logic [CW_W-1:0] CW_RESET = CW_W'(1) << MASK_BIT;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [MODE_W-1:0] mode;
    logic              level;
  } irq_req_t;

  typedef struct packed {
    logic     periodic;
    logic     masked;
    irq_req_t req;
  } lvt_cfg_t;

  function automatic lvt_cfg_t decode_cw(input logic [CW_W-1:0] w);
    lvt_cfg_t c;
    c.periodic   = w[PER_BIT];
    c.masked     = w[MASK_BIT];
    c.req.vector = w[VEC_LSB +: VEC_W];
    c.req.mode   = w[MODE_LSB +: MODE_W];
    c.req.level  = w[TRIG_BIT];
    return c;
  endfunction
endpackage

// File: rtl/lvt_ctrl_reg.sv
module lvt_ctrl_reg
  import lvt_timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [CW_W-1:0] wdata,
  output logic [CW_W-1:0] word,
  output lvt_cfg_t        cfg
);
  logic [CW_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  word_q <= CW_RESET;
    else if (wr) word_q <= wdata;
  end

  assign word = word_q;
  assign cfg  = decode_cw(word_q);
endmodule

// File: rtl/lvt_counter.sv
module lvt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] init_q;
  logic [CNT_W-1:0] cnt_q;
  logic             running;

  assign running = (cnt_q != ZERO);
  assign expire  = tick && !load && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= ZERO;
      cnt_q  <= ZERO;
    end else if (load) begin
      init_q <= load_val;
      cnt_q  <= load_val;
    end else if (tick && running) begin
      if (cnt_q == ONE) cnt_q <= periodic ? init_q : ZERO;
      else              cnt_q <= cnt_q - ONE;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/lvt_req_out.sv
module lvt_req_out
  import lvt_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     expire,
  input  lvt_cfg_t cfg,
  output logic     valid,
  output irq_req_t req
);
  logic     valid_q;
  irq_req_t req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      req_q   <= '0;
    end else begin
      valid_q <= expire && !cfg.masked;
      if (expire) req_q <= cfg.req;
    end
  end

  assign valid = valid_q;
  assign req   = req_q;
endmodule

// File: rtl/lvt_timer.sv
module lvt_timer
  import lvt_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [CW_W-1:0]      wr_data,
  output logic [CNT_W-1:0]     cur_count,
  output logic [CW_W-1:0]      ctrl_word,
  output logic                 irq_valid,
  output logic [VEC_W-1:0]     irq_vector,
  output logic [MODE_W-1:0]    irq_mode,
  output logic                 irq_level
);
  lvt_cfg_t cfg;
  irq_req_t req;
  logic     expire;
  logic     wr_cw;
  logic     wr_cnt;

  assign wr_cw  = wr_en && !wr_sel;
  assign wr_cnt = wr_en &&  wr_sel;

  lvt_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_cw),
    .wdata (wr_data),
    .word  (ctrl_word),
    .cfg   (cfg)
  );

  lvt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_cnt),
    .load_val (wr_data[CNT_W-1:0]),
    .tick     (tick_en),
    .periodic (cfg.periodic),
    .count    (cur_count),
    .expire   (expire)
  );

  lvt_req_out u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .cfg    (cfg),
    .valid  (irq_valid),
    .req    (req)
  );

  assign irq_vector = req.vector;
  assign irq_mode   = req.mode;
  assign irq_level  = req.level;
endmodule

// File: rtl/lvt_timer_chk.sv
module lvt_timer_chk
  import lvt_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [CW_W-1:0]   wr_data,
  input logic [CNT_W-1:0]  cur_count,
  input logic [CW_W-1:0]   ctrl_word,
  input logic              irq_valid,
  input logic [VEC_W-1:0]  irq_vector,
  input logic [MODE_W-1:0] irq_mode,
  input logic              irq_level,
  input logic [CNT_W-1:0]  init_count
);
  logic at_one, no_load;
  assign at_one  = (cur_count == CNT_W'(1));
  assign no_load = !(wr_en && wr_sel);

  p_reset_mask_r1: assert property (@(posedge clk) !rst_n |=> ctrl_word == CW_RESET && cur_count == '0 && !irq_valid);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && no_load && cur_count > CNT_W'(1) |=> cur_count == $past(cur_count) - CNT_W'(1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && no_load |=> $stable(cur_count));

  p_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && no_load && at_one && !ctrl_word[MASK_BIT] |=>
      irq_valid && irq_vector == $past(ctrl_word[VEC_LSB +: VEC_W]) &&
      irq_mode == $past(ctrl_word[MODE_LSB +: MODE_W]) && irq_level == $past(ctrl_word[TRIG_BIT]));

  p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[MASK_BIT] |=> !irq_valid);

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && no_load && at_one && ctrl_word[PER_BIT] |=> cur_count == $past(init_count));

  p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && no_load && at_one && !ctrl_word[PER_BIT] |=> cur_count == '0);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel |=> cur_count == $past(wr_data[CNT_W-1:0]));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_count == '0 && no_load |=> cur_count == '0 && !irq_valid);

  p_cw_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel && !tick_en |=> ctrl_word == $past(wr_data) && $stable(cur_count));
endmodule

bind lvt_timer lvt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .cur_count  (cur_count),
  .ctrl_word  (ctrl_word),
  .irq_valid  (irq_valid),
  .irq_vector (irq_vector),
  .irq_mode   (irq_mode),
  .irq_level  (irq_level),
  .init_count (u_cnt.init_q)
);

// File: tb/lvt_timer_tb.sv
module lvt_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] cur_count;
  logic [31:0] ctrl_word;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  logic [2:0]  irq_mode;
  logic        irq_level;

  lvt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cur_count(cur_count), .ctrl_word(ctrl_word),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_mode(irq_mode), .irq_level(irq_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    int         cyc;
    logic [7:0] vec;
    logic [2:0] mode;
    logic       lvl;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [31:0] m_ctrl = 32'h0001_0000;
  logic [31:0] m_init = 0;
  logic [31:0] m_cnt  = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Monitor: pops expected requests as strobes appear
  always @(negedge clk) begin
    if (rst_n && !done && irq_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected strobe actual=%h expected=none", irq_vector);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.cyc + 1 != cyc || e.vec !== irq_vector || e.mode !== irq_mode || e.lvl !== irq_level) begin
          errors++;
          $display("FAIL R3 strobe actual=cyc%0d/%h/%h/%b expected=cyc%0d/%h/%h/%b",
                   cyc, irq_vector, irq_mode, irq_level, e.cyc + 1, e.vec, e.mode, e.lvl);
        end
      end
    end
  end

  // Driver: model step per tick, pushing expected requests
  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      if (m_cnt == 1) begin
        if (!m_ctrl[16]) exp_q.push_back('{cyc, m_ctrl[7:0], m_ctrl[10:8], m_ctrl[15]});
        m_cnt = m_ctrl[17] ? m_init : 0;
      end else if (m_cnt != 0) m_cnt = m_cnt - 1;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d, input logic tk);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; tick_en = tk;
    if (sel) begin m_init = d; m_cnt = d; end
    else m_ctrl = d;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic finish_run();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 missing strobes actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count", cur_count, 0);
    check("R1 ctrl", ctrl_word, 32'h0001_0000);
    check("R1 strobe", {31'b0, irq_valid}, 0);

    // R1: reset mask blocks request, one-shot stop
    wr(1'b1, 2, 1'b0);
    do_ticks(4);
    check("R1 stop after masked expiry", cur_count, m_cnt);

    // R9, R2, R3, R6: one-shot unmasked
    wr(1'b0, 32'h0000_8241, 1'b0);
    check("R9 ctrl readback", ctrl_word, 32'h0000_8241);
    wr(1'b1, 5, 1'b0);
    check("R7 load", cur_count, 5);
    do_ticks(3);
    check("R2 step", cur_count, 2);
    idle(3);
    check("R2 hold", cur_count, 2);
    do_ticks(2);
    idle(1);
    check("R6 stop", cur_count, 0);
    do_ticks(4);
    check("R6 stays stopped", cur_count, 0);

    // R5: periodic unmasked
    wr(1'b0, 32'h0002_047A, 1'b0);
    wr(1'b1, 3, 1'b0);
    do_ticks(9);
    idle(1);
    check("R5 periodic reload", cur_count, 3);

    // R4, R5: periodic masked still reloads
    wr(1'b0, 32'h0003_7F7A, 1'b0);
    check("R9 status bits stored", ctrl_word, 32'h0003_7F7A);
    wr(1'b1, 2, 1'b0);
    do_ticks(4);
    idle(1);
    check("R4 masked reload", cur_count, 2);

    // R7: rewrite with same value restarts
    wr(1'b0, 32'h0000_0133, 1'b0);
    wr(1'b1, 4, 1'b0);
    do_ticks(2);
    check("R7 mid count", cur_count, 2);
    wr(1'b1, 4, 1'b0);
    check("R7 same value restart", cur_count, 4);
    do_ticks(1);
    check("R2 after restart", cur_count, 3);
    wr(1'b1, 6, 1'b1);
    check("R7 write beats tick", cur_count, 6);
    do_ticks(6);
    idle(1);
    check("R6 expired", cur_count, 0);

    // R8: zero initial count
    wr(1'b1, 0, 1'b0);
    do_ticks(5);
    check("R8 zero stays", cur_count, 0);

    // R9: control change mid count; fields taken at expiry
    wr(1'b1, 5, 1'b0);
    do_ticks(1);
    wr(1'b0, 32'h0000_85C3, 1'b0);
    check("R9 count untouched", cur_count, 4);
    do_ticks(4);
    idle(1);

    // R5: periodic with count one fires every tick
    wr(1'b0, 32'h0002_8311, 1'b0);
    wr(1'b1, 1, 1'b0);
    do_ticks(3);
    idle(1);
    check("R5 count one reload", cur_count, 1);
    wr(1'b0, 32'h0001_0000, 1'b0);
    idle(2);
    finish_run();
  end
endmodule